// File: doc/BRIEF.md
# Board Controller Configuration Transfer Engine

This block runs single configuration transfers between a processor and an external board controller. Software programs a data word and then a control word. The control word carries a self-clearing start flag, a transfer direction and a function code. The engine then raises a request toward the controller and holds the direction, function and outgoing data steady until the controller answers with an acknowledge or an error, or until a programmable cycle budget runs out.

When a transfer ends, a sticky status register reports completion and error. A read that completes without error loads the returned word into the data register. Two function codes have a side effect: when a write with one of them completes without error, the engine emits a one-cycle pulse on a dedicated shutdown line or a dedicated reboot line. While a transfer is in flight, software writes to the control and data registers are dropped.

Top module: `cfgx_engine`

## Requirements
- R1: Registers sit at byte offsets 0xA0 (data), 0xA4 (control) and 0xA8 (status). In the control word, bit 31 is start, bit 30 selects write when 1 and read when 0, and bits 25:20 hold the function code. In the status word, bit 0 is done and bit 1 is error. Reads of any other offset return zero.
- R2: A control write accepted while idle with bit 31 set raises `xfer_req` from the next cycle. For as long as the request is high, `xfer_write` and `xfer_func` show the control fields and `xfer_wdata` shows the data register.
- R3: The start bit clears itself on acceptance, so reading the control register back shows bit 31 as 0 and the other bits as written.
- R4: Every accepted control write clears both status bits, whether or not it starts a transfer.
- R5: An acknowledge sampled while the request is high ends the transfer. The request drops in the next cycle, and status then reads done=1, error=0.
- R6: A read transfer that completes without error loads `xfer_rdata` into the data register. A read that ends in error leaves the data register unchanged.
- R7: An error response sampled while the request is high ends the transfer with done=1 and error=1.
- R8: If no response arrives while the request has been high for max(`tmo_cycles`,1) cycles, the request drops and status reads done=1, error=1.
- R9: While a transfer is in flight, writes to the control and data registers have no effect.
- R10: A write transfer with function code 0x08 that completes without error gives a one-cycle pulse on `shutdown_pulse`. Code 0x09 does the same on `reboot_pulse`. The pulse is high in the same cycle that status first shows done. Reads, failed transfers and other codes give no pulse.
- R11: After reset all registers read zero, and the request and both pulse lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmo_cycles | input | TMO_W | Response budget in cycles (0 acts as 1) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset for read and write |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` (combinational) |
| xfer_req | output | 1 | Transfer request to the board controller |
| xfer_write | output | 1 | Direction of the request, 1 = write |
| xfer_func | output | 6 | Function code of the request |
| xfer_wdata | output | DATA_W | Outgoing data word |
| xfer_ack | input | 1 | Controller acknowledge |
| xfer_err | input | 1 | Controller error response |
| xfer_rdata | input | DATA_W | Returned data, valid with the acknowledge |
| shutdown_pulse | output | 1 | One-cycle shutdown command |
| reboot_pulse | output | 1 | One-cycle reboot command |

## Verification
The assertions check on every cycle that the request holds its direction, function and data steady and that a start from an idle engine makes it busy. They also check that a response ends the request, that an accepted control write leaves clean status, and that the two command pulses are never both high and never last more than one cycle. Only the directed scenarios can show the rest. These are the exact register encodings, the self-cleared start bit, capture or retention of read data, the timeout cycle count, writes being dropped while busy, and which function codes lead to a pulse.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
    localparam int unsigned FUNC_W    = 6;
    localparam int unsigned FUNC_LSB  = 20;
    localparam int unsigned START_BIT = 31;
    localparam int unsigned DIR_BIT   = 30;

    localparam logic [7:0] OFS_DATA = 8'hA0;
    localparam logic [7:0] OFS_CTRL = 8'hA4;
    localparam logic [7:0] OFS_STAT = 8'hA8;

    localparam logic [FUNC_W-1:0] FN_SHUTDOWN = 6'h08;
    localparam logic [FUNC_W-1:0] FN_REBOOT   = 6'h09;

    typedef struct packed {
        logic              dir_wr;
        logic [FUNC_W-1:0] func;
    } xfer_cmd_t;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_WAIT = 1'b1
    } seq_state_e;
endpackage

// File: rtl/cfgx_regs.sv
module cfgx_regs
    import cfgx_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              busy,
    input  logic              fin,
    input  logic              fin_err,
    input  logic [DATA_W-1:0] rdata_in,
    output logic              start,
    output xfer_cmd_t         cmd,
    output logic [DATA_W-1:0] wdata_out
);
    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] data;
        logic              done;
        logic              err;
    } regs_t;

    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);

    regs_t r_d, r_q;
    logic  hit_data, hit_ctrl;

    always_comb begin
        r_d      = r_q;
        start    = 1'b0;
        hit_data = reg_wr && (reg_addr == A_DATA);
        hit_ctrl = reg_wr && (reg_addr == A_CTRL);
        if (!busy) begin
            if (hit_data) begin
                r_d.data = reg_wdata;
            end
            if (hit_ctrl) begin
                r_d.ctrl            = reg_wdata;
                r_d.ctrl[START_BIT] = 1'b0;
                r_d.done            = 1'b0;
                r_d.err             = 1'b0;
                start               = reg_wdata[START_BIT];
            end
        end
        if (fin) begin
            r_d.done = 1'b1;
            r_d.err  = fin_err;
            if (!r_q.ctrl[DIR_BIT] && !fin_err) begin
                r_d.data = rdata_in;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_DATA:  reg_rdata = r_q.data;
            A_CTRL:  reg_rdata = r_q.ctrl;
            A_STAT:  reg_rdata = {{(DATA_W-2){1'b0}}, r_q.err, r_q.done};
            default: reg_rdata = '0;
        endcase
    end

    assign cmd.dir_wr = r_q.ctrl[DIR_BIT];
    assign cmd.func   = r_q.ctrl[FUNC_LSB +: FUNC_W];
    assign wdata_out  = r_q.data;

    // R4: an accepted control write leaves clean status behind it
    p_status_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CTRL && !busy) |=> (!r_q.done && !r_q.err));

    // R9: data register holds while a transfer is in flight and no response arrives
    p_data_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fin) |=> $stable(r_q.data));
endmodule

// File: rtl/cfgx_seq.sv
module cfgx_seq
    import cfgx_pkg::*;
#(
    parameter int unsigned TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [TMO_W-1:0] tmo_cycles,
    input  logic             ack,
    input  logic             err_rsp,
    output logic             busy,
    output logic             fin,
    output logic             fin_err
);
    typedef struct packed {
        seq_state_e       st;
        logic [TMO_W-1:0] cnt;
    } seq_t;

    seq_t           s_d, s_q;
    logic [TMO_W:0] cnt_next;

    always_comb begin
        s_d      = s_q;
        fin      = 1'b0;
        fin_err  = 1'b0;
        cnt_next = {1'b0, s_q.cnt} + (TMO_W+1)'(1);
        case (s_q.st)
            SEQ_IDLE: begin
                if (start) begin
                    s_d.st  = SEQ_WAIT;
                    s_d.cnt = '0;
                end
            end
            SEQ_WAIT: begin
                if (ack || err_rsp) begin
                    fin     = 1'b1;
                    fin_err = err_rsp;
                    s_d.st  = SEQ_IDLE;
                    s_d.cnt = '0;
                end else if (cnt_next >= {1'b0, tmo_cycles}) begin
                    fin     = 1'b1;
                    fin_err = 1'b1;
                    s_d.st  = SEQ_IDLE;
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = cnt_next[TMO_W-1:0];
                end
            end
            default: s_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy = (s_q.st == SEQ_WAIT);

    // R2: a start seen by an idle sequencer makes it busy next cycle
    p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R5: any controller response ends the request
    p_resp_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (ack || err_rsp)) |=> !busy);
endmodule

// File: rtl/cfgx_fdec.sv
module cfgx_fdec
    import cfgx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      fin,
    input  logic      fin_err,
    input  xfer_cmd_t cmd,
    output logic      shutdown_pulse,
    output logic      reboot_pulse
);
    typedef struct packed {
        logic sd;
        logic rb;
    } pulse_t;

    pulse_t p_d, p_q;
    logic   good_wr;

    always_comb begin
        good_wr = fin && !fin_err && cmd.dir_wr;
        p_d.sd  = good_wr && (cmd.func == FN_SHUTDOWN);
        p_d.rb  = good_wr && (cmd.func == FN_REBOOT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign shutdown_pulse = p_q.sd;
    assign reboot_pulse   = p_q.rb;

    // R10: the two command lines are never high together
    p_pulse_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(shutdown_pulse && reboot_pulse));

    // R10: each pulse lasts a single cycle
    p_pulse_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (shutdown_pulse || reboot_pulse) |=> !(shutdown_pulse || reboot_pulse));
endmodule

// File: rtl/cfgx_engine.sv
module cfgx_engine
    import cfgx_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned TMO_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TMO_W-1:0]  tmo_cycles,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              xfer_req,
    output logic              xfer_write,
    output logic [5:0]        xfer_func,
    output logic [DATA_W-1:0] xfer_wdata,
    input  logic              xfer_ack,
    input  logic              xfer_err,
    input  logic [DATA_W-1:0] xfer_rdata,
    output logic              shutdown_pulse,
    output logic              reboot_pulse
);
    logic      busy, fin, fin_err, start;
    xfer_cmd_t cmd;

    cfgx_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .fin       (fin),
        .fin_err   (fin_err),
        .rdata_in  (xfer_rdata),
        .start     (start),
        .cmd       (cmd),
        .wdata_out (xfer_wdata)
    );

    cfgx_seq #(.TMO_W(TMO_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .tmo_cycles (tmo_cycles),
        .ack        (xfer_ack),
        .err_rsp    (xfer_err),
        .busy       (busy),
        .fin        (fin),
        .fin_err    (fin_err)
    );

    cfgx_fdec u_fdec (
        .clk            (clk),
        .rst_n          (rst_n),
        .fin            (fin),
        .fin_err        (fin_err),
        .cmd            (cmd),
        .shutdown_pulse (shutdown_pulse),
        .reboot_pulse   (reboot_pulse)
    );

    assign xfer_req   = busy;
    assign xfer_write = cmd.dir_wr;
    assign xfer_func  = cmd.func;

    // R2: request fields stay put for the whole request
    p_req_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && $past(xfer_req)) |->
            ($stable(xfer_wdata) && $stable(xfer_func) && $stable(xfer_write)));
endmodule

// File: tb/test_cfgx_engine.sv
module test_cfgx_engine;
    localparam logic [7:0] A_DATA = 8'hA0;
    localparam logic [7:0] A_CTRL = 8'hA4;
    localparam logic [7:0] A_STAT = 8'hA8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] tmo_cycles = 16'd50;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        xfer_req, xfer_write;
    logic [5:0]  xfer_func;
    logic [31:0] xfer_wdata;
    logic        xfer_ack = 1'b0;
    logic        xfer_err = 1'b0;
    logic [31:0] xfer_rdata = '0;
    logic        shutdown_pulse, reboot_pulse;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    cfgx_engine i_cfgx_engine (
        .clk(clk), .rst_n(rst_n), .tmo_cycles(tmo_cycles),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .xfer_req(xfer_req), .xfer_write(xfer_write), .xfer_func(xfer_func),
        .xfer_wdata(xfer_wdata), .xfer_ack(xfer_ack), .xfer_err(xfer_err),
        .xfer_rdata(xfer_rdata), .shutdown_pulse(shutdown_pulse), .reboot_pulse(reboot_pulse)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    // Controller model: waits for a request, waits dly cycles, answers once.
    task automatic respond(input int dly, input bit e, input logic [31:0] rv);
        while (!xfer_req) @(negedge clk);
        repeat (dly) @(negedge clk);
        xfer_ack = !e; xfer_err = e; xfer_rdata = rv;
        @(negedge clk);
        xfer_ack = 1'b0; xfer_err = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(A_DATA, v); chk(v == 0, "R11 data", v, 0);
        rd(A_CTRL, v); chk(v == 0, "R11 ctrl", v, 0);
        rd(A_STAT, v); chk(v == 0, "R11 stat", v, 0);
        chk(!xfer_req && !shutdown_pulse && !reboot_pulse, "R11 outputs",
            {xfer_req, shutdown_pulse, reboot_pulse}, 0);
        rd(8'h00, v); chk(v == 0, "R1 unmapped", v, 0);
    endtask

    task automatic t_shutdown;
        logic [31:0] v;
        wr(A_DATA, 32'h0000_1234);
        wr(A_CTRL, 32'hC080_0000);
        chk(xfer_req && xfer_write && xfer_func == 6'h08, "R2 fields",
            {xfer_req, xfer_write, xfer_func}, {1'b1, 1'b1, 6'h08});
        chk(xfer_wdata == 32'h1234, "R2 wdata", xfer_wdata, 32'h1234);
        rd(A_CTRL, v); chk(v == 32'h4080_0000, "R3 self clear", v, 32'h4080_0000);
        respond(2, 1'b0, '0);
        chk(!xfer_req, "R5 req drop", xfer_req, 0);
        rd(A_STAT, v); chk(v == 1, "R5 status", v, 1);
        chk(shutdown_pulse && !reboot_pulse, "R10 shutdown pulse",
            {shutdown_pulse, reboot_pulse}, 2'b10);
        @(negedge clk);
        chk(!shutdown_pulse, "R10 one cycle", shutdown_pulse, 0);
    endtask

    task automatic t_clear;
        logic [31:0] v;
        wr(A_CTRL, 32'h0000_0000);
        rd(A_STAT, v); chk(v == 0, "R4 status cleared", v, 0);
        chk(!xfer_req, "R4 no start", xfer_req, 0);
    endtask

    task automatic t_reboot;
        wr(A_CTRL, 32'hC090_0000);
        respond(0, 1'b0, '0);
        chk(reboot_pulse && !shutdown_pulse, "R10 reboot pulse",
            {shutdown_pulse, reboot_pulse}, 2'b01);
    endtask

    task automatic t_read;
        logic [31:0] v;
        wr(A_CTRL, 32'h80A0_0000);
        chk(xfer_req && !xfer_write && xfer_func == 6'h0A, "R2 read fields",
            {xfer_req, xfer_write, xfer_func}, {1'b1, 1'b0, 6'h0A});
        respond(1, 1'b0, 32'hCAFE_F00D);
        rd(A_DATA, v); chk(v == 32'hCAFE_F00D, "R6 capture", v, 32'hCAFE_F00D);
        chk(!shutdown_pulse && !reboot_pulse, "R10 no pulse on read",
            {shutdown_pulse, reboot_pulse}, 0);
    endtask

    task automatic t_err_write;
        logic [31:0] v;
        wr(A_CTRL, 32'hC080_0000);
        respond(1, 1'b1, '0);
        rd(A_STAT, v); chk(v == 3, "R7 error status", v, 3);
        chk(!shutdown_pulse, "R10 no pulse on error", shutdown_pulse, 0);
    endtask

    task automatic t_busy_ignore;
        logic [31:0] v;
        wr(A_DATA, 32'h0000_1111);
        wr(A_CTRL, 32'h80A0_0000);
        wr(A_DATA, 32'h0000_5555);
        wr(A_CTRL, 32'h0000_0000);
        rd(A_CTRL, v); chk(v == 32'h00A0_0000, "R9 ctrl ignored", v, 32'h00A0_0000);
        rd(A_DATA, v); chk(v == 32'h1111, "R9 data ignored", v, 32'h1111);
        chk(xfer_req, "R9 still busy", xfer_req, 1);
        respond(0, 1'b1, 32'hDEAD_BEEF);
        rd(A_DATA, v); chk(v == 32'h1111, "R6 kept on error", v, 32'h1111);
        rd(A_STAT, v); chk(v == 3, "R7 read error", v, 3);
    endtask

    task automatic t_timeout;
        logic [31:0] v;
        int n = 0;
        tmo_cycles = 16'd5;
        wr(A_CTRL, 32'hC080_0000);
        while (xfer_req && n < 100) begin
            n++;
            @(negedge clk);
        end
        chk(n == 5, "R8 request cycles", n, 5);
        rd(A_STAT, v); chk(v == 3, "R8 timeout status", v, 3);
        chk(!shutdown_pulse, "R10 no pulse on timeout", shutdown_pulse, 0);
        tmo_cycles = 16'd50;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_shutdown();
        t_clear();
        t_reboot();
        t_read();
        t_err_write();
        t_busy_ignore();
        t_timeout();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule